// File: doc/BRIEF.md
# Chainable Serial Control Port

This block is the serial slave port of a four-channel load-switch controller. A host drives chip select, serial clock and serial data in; the block returns serial data out together with an output-enable for the pad. The port runs entirely in a fast system clock domain. It synchronizes the serial pins, finds their edges and shifts one 8-bit word in and one status word out per frame.

A received word reaches the control register only when the frame carried a nonzero whole number of 8-bit groups. Several ports can therefore share one chip select, wired SO to SI in a chain. Each port passes along every bit that it pushes out of its shift register, and each one keeps the last byte it received. A transmission-error flag is set by reset, by a frame with a bad clock count and by a limp-home request. The flag appears on the data output in the short window between chip select falling and the first clock rise, ORed with the incoming data level. Because of the OR, a fault anywhere in the chain reaches the host.

The design assumes the system clock runs at least eight times faster than the serial clock.

Top module: `spi_chain_slave`

## Requirements
- R1: While chip select is high (inactive), `so_oe` is 0, and toggling the serial clock or data changes neither `ctrl_q` nor `tx_err`, and raises no `wr_stb`.
- R2: Data in is sampled on the falling serial-clock edge and data out changes on the rising edge; both shift most significant bit first.
- R3: When chip select falls, `stat_in` is loaded in parallel, so the first bits out of a frame are `stat_in[7]` down to `stat_in[0]`. Bit 7 down to bit 0 are: channel 3 open-load, channel 3 fault, channel 2 open-load, channel 2 fault, channel 1 open-load, channel 1 fault, channel 0 open-load, channel 0 fault.
- R4: Between chip select falling and the first rising serial-clock edge, `so` equals `tx_err` OR the current data-in level.
- R5: When chip select rises, the shifted word is written to `ctrl_q` only if the count of falling clocks in the frame is a nonzero multiple of 8. The write comes with a single-cycle `wr_stb` pulse. A frame with any other count, including zero, leaves `ctrl_q` unchanged.
- R6: `tx_err` is 1 after reset, is set to 1 by a frame with a bad clock count, and is cleared to 0 by a frame whose count is valid.
- R7: In a 16-clock frame the port keeps the last 8 bits received. On `so` it emits its status byte followed by the first 8 bits received.
- R8: While `limp_home` is 1, no frame writes `ctrl_q`, and `tx_err` is held at 1.
- R9: After reset `ctrl_q` is 0 and `wr_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; 0 means the pad floats |
| limp_home | input | 1 | Fail-safe request; invalidates all frames |
| stat_in | input | W | Status word to be sent |
| ctrl_q | output | W | Control register |
| wr_stb | output | 1 | One-cycle pulse when `ctrl_q` is written |
| tx_err | output | 1 | Transmission-error flag |

## Verification
The checker assumes that the serial pins change no faster than every few system clocks. It also assumes that `limp_home` and `stat_in` are already in the system domain. Given those conditions, the output-enable follows chip select after exactly two synchronizer stages. The bench holds every serial half-period at eight system clocks and moves data-in only in the middle of the clock-low phase. It separates chip-select edges from clock edges by several cycles and changes all inputs on the falling system-clock edge.

// File: rtl/spi_chain_slave.sv
module spi_chain_slave #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         si,
  output logic         so,
  output logic         so_oe,
  input  logic         limp_home,
  input  logic [W-1:0] stat_in,
  output logic [W-1:0] ctrl_q,
  output logic         wr_stb,
  output logic         tx_err
);
  localparam int CW = $clog2(W);

  logic [2:0]    cs_p, ck_p;
  logic [1:0]    si_p;
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          cnt_ok, lead, out_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= 3'b111;
      ck_p <= 3'b000;
      si_p <= 2'b00;
    end else begin
      cs_p <= {cs_p[1:0], cs_n};
      ck_p <= {ck_p[1:0], sclk};
      si_p <= {si_p[0], si};
    end
  end

  wire sel     = ~cs_p[1];
  wire cs_fall = cs_p[2] & ~cs_p[1];
  wire cs_rise = ~cs_p[2] & cs_p[1];
  wire ck_rise = sel & ~ck_p[2] & ck_p[1];
  wire ck_fall = sel & ck_p[2] & ~ck_p[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      cnt     <= '0;
      cnt_ok  <= 1'b0;
      lead    <= 1'b0;
      out_bit <= 1'b1;
      ctrl_q  <= '0;
      wr_stb  <= 1'b0;
      tx_err  <= 1'b1;
    end else begin
      wr_stb <= 1'b0;
      if (cs_fall) begin
        sh     <= stat_in;
        lead   <= 1'b1;
        cnt    <= '0;
        cnt_ok <= 1'b0;
      end else if (cs_rise) begin
        lead <= 1'b0;
        if (cnt_ok && !limp_home) begin
          ctrl_q <= sh;
          wr_stb <= 1'b1;
          tx_err <= 1'b0;
        end else begin
          tx_err <= 1'b1;
        end
      end else begin
        if (ck_rise) begin
          lead    <= 1'b0;
          out_bit <= sh[W-1];
        end
        if (ck_fall) begin
          sh     <= {sh[W-2:0], si_p[1]};
          cnt    <= cnt + 1'b1;
          cnt_ok <= (cnt == CW'(W-1));
        end
      end
      if (limp_home) tx_err <= 1'b1;
    end
  end

  assign so_oe = sel;
  assign so    = lead ? (tx_err | si_p[1]) : out_bit;
endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         sclk,
  input logic         si,
  input logic         so,
  input logic         so_oe,
  input logic         limp_home,
  input logic [W-1:0] stat_in,
  input logic [W-1:0] ctrl_q,
  input logic         wr_stb,
  input logic         tx_err
);
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  AST_OE_TRACKS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (so_oe == !$past(cs_n, 2))); // R1

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R5

  AST_CTRL_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && !$stable(ctrl_q)) |-> wr_stb); // R5

  AST_STB_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !tx_err); // R6

  AST_LIMP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && $past(limp_home)) |-> (!wr_stb && tx_err)); // R8
endmodule

bind spi_chain_slave spi_chain_slave_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si), .so(so),
  .so_oe(so_oe), .limp_home(limp_home), .stat_in(stat_in), .ctrl_q(ctrl_q),
  .wr_stb(wr_stb), .tx_err(tx_err)
);

// File: tb/tb_spi_chain_slave.sv
module tb_spi_chain_slave;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, si = 0, limp_home = 0;
  logic [7:0] stat_in = 8'h00;
  logic so, so_oe, wr_stb, tx_err;
  logic [7:0] ctrl_q;

  int compared = 0, mismatched = 0;

  spi_chain_slave #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si), .so(so),
    .so_oe(so_oe), .limp_home(limp_home), .stat_in(stat_in), .ctrl_q(ctrl_q),
    .wr_stb(wr_stb), .tx_err(tx_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: pin history queues, frame state as plain variables
  logic hc[$], hk[$], hs[$];
  logic [7:0] m_sh, m_ctrl;
  int   m_cnt;
  logic m_ok, m_lead, m_out, m_stb, m_err;

  task automatic model_reset();
    hc = {1'b1, 1'b1, 1'b1, 1'b1};
    hk = {1'b0, 1'b0, 1'b0, 1'b0};
    hs = {1'b0, 1'b0, 1'b0, 1'b0};
    m_sh = 0; m_ctrl = 0; m_cnt = 0; m_ok = 0; m_lead = 0; m_out = 1;
    m_stb = 0; m_err = 1;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      hc.push_front(cs_n); hk.push_front(sclk); hs.push_front(si);
      void'(hc.pop_back()); void'(hk.pop_back()); void'(hs.pop_back());
      m_stb = 0;
      if (hc[3] && !hc[2]) begin
        m_sh = stat_in; m_lead = 1; m_cnt = 0; m_ok = 0;
      end else if (!hc[3] && hc[2]) begin
        m_lead = 0;
        if (m_ok && !limp_home) begin m_ctrl = m_sh; m_stb = 1; m_err = 0; end
        else m_err = 1;
      end else if (!hc[2]) begin
        if (!hk[3] && hk[2]) begin m_lead = 0; m_out = m_sh[7]; end
        if (hk[3] && !hk[2]) begin
          m_sh = {m_sh[6:0], hs[2]};
          m_cnt = (m_cnt + 1) % 8;
          m_ok = (m_cnt == 0);
        end
      end
      if (limp_home) m_err = 1;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R5", "ctrl_q vs model", ctrl_q, m_ctrl);
      check("R5", "wr_stb vs model", wr_stb, m_stb);
      check("R6", "tx_err vs model", tx_err, m_err);
      check("R1", "so_oe vs model", so_oe, !hc[1]);
      if (so_oe) check(m_lead ? "R4" : "R2", "so vs model", so, m_lead ? (m_err | hs[1]) : m_out);
    end
  end

  task automatic run_frame(input logic [31:0] d, input int n,
                           output logic [31:0] got, output logic lead_so);
    si = (n > 0) ? d[n-1] : 1'b0;
    @(negedge clk) cs_n = 0;
    repeat (8) @(negedge clk);
    lead_so = so;
    got = 0;
    for (int i = n - 1; i >= 0; i--) begin
      si = d[i];
      repeat (4) @(negedge clk);
      sclk = 1;
      repeat (8) @(negedge clk);
      got = {got[30:0], so};
      sclk = 0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (12) @(negedge clk);
  endtask

  logic done = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    logic lead;
    repeat (4) @(negedge clk);
    check("R9", "reset ctrl_q", ctrl_q, 8'h00);
    check("R9", "reset wr_stb", wr_stb, 0);
    check("R6", "reset tx_err", tx_err, 1);
    check("R1", "reset so_oe", so_oe, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // valid byte; lead shows error flag (1) OR si
    stat_in = 8'h3C;
    run_frame(32'hA5, 8, got, lead);
    check("R4", "lead with err=1", lead, 1);
    check("R3", "status shifted out", got[7:0], 8'h3C);
    check("R5", "ctrl after valid", ctrl_q, 8'hA5);
    check("R6", "err after valid", tx_err, 0);

    // err=0, si msb=0 -> lead 0
    stat_in = 8'h81;
    run_frame(32'h5A, 8, got, lead);
    check("R4", "lead with err=0 si=0", lead, 0);
    check("R2", "msb-first out", got[7:0], 8'h81);
    check("R5", "ctrl second", ctrl_q, 8'h5A);

    // bad count: 5 clocks
    run_frame(32'h1F, 5, got, lead);
    check("R4", "lead err=0 si=1", lead, 1);
    check("R5", "ctrl kept after 5 clocks", ctrl_q, 8'h5A);
    check("R6", "err after bad", tx_err, 1);

    // err=1, si=0 -> lead 1; 9 clocks invalid
    run_frame(32'h0F0, 9, got, lead);
    check("R4", "lead err=1 si=0", lead, 1);
    check("R5", "ctrl kept after 9 clocks", ctrl_q, 8'h5A);

    // zero-clock frame
    run_frame(32'h0, 0, got, lead);
    check("R5", "ctrl kept after 0 clocks", ctrl_q, 8'h5A);
    check("R6", "err after 0 clocks", tx_err, 1);

    // activity with CS high
    run_frame(32'h77, 8, got, lead);
    for (int i = 0; i < 10; i++) begin
      si = i[0];
      repeat (4) @(negedge clk); sclk = 1;
      repeat (4) @(negedge clk); sclk = 0;
      check("R1", "so_oe idle", so_oe, 0);
    end
    repeat (6) @(negedge clk);
    check("R1", "ctrl untouched idle", ctrl_q, 8'h77);
    check("R1", "err untouched idle", tx_err, 0);

    // two-device chain frame
    stat_in = 8'h81;
    run_frame(32'hC396, 16, got, lead);
    check("R7", "keeps last byte", ctrl_q, 8'h96);
    check("R7", "forwarded stream", got[15:0], 16'h81C3);

    // limp home
    limp_home = 1;
    run_frame(32'h11, 8, got, lead);
    check("R8", "ctrl blocked", ctrl_q, 8'h96);
    check("R8", "err held", tx_err, 1);
    limp_home = 0;
    repeat (4) @(negedge clk);
    run_frame(32'h22, 8, got, lead);
    check("R8", "ctrl after limp released", ctrl_q, 8'h22);
    check("R6", "err cleared", tx_err, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule